// File: doc/BRIEF.md
# Thinning Pixel Erosion Slice

This block decides whether the centre pixel of one 3x3 window of a bi-level image survives one sub-iteration of a two-pass thinning algorithm. It takes the nine window bits and a pass-select bit. It produces the next value of the centre pixel and a flag that marks an erosion. The centre may be removed only when three tests agree. The neighbour count must be moderate. The pixel must border exactly one foreground region. A directional test on the four edge neighbours, which alternates between the two passes, must also succeed.

A caller that scans an image instantiates one slice per output pixel. It feeds each slice its window and ORs the change flags to detect convergence. The decision logic is purely combinational. A parameter can place a register stage on the two outputs, so the slice can be timed and tested on its own.

Top module: `thin_erode_slice`

## Requirements
- R1: Window bit `win[4]` is the centre pixel. The top row is bits 8,7,6 from right to left, the middle row is bits 5 (east), 4, 3 (west), and the bottom row is bits 2,1,0 from right to left. Going clockwise from the top-left, the neighbours are q0=win[6], q1=win[7], q2=win[8], q3=win[5], q4=win[2], q5=win[1], q6=win[0] and q7=win[3].
- R2: The count test passes only when the number of foreground neighbours is between 2 and 6 inclusive. A count of 0, 1, 7 or 8 keeps the centre pixel.
- R3: The connectivity test passes only when exactly one background-to-foreground step occurs while walking q0..q7 and back to q0.
- R4: With `pass_sel`=0, the directional test passes when east is 0, or south is 0, or north and west are both 0.
- R5: With `pass_sel`=1, the directional test passes when north is 0, or west is 0, or east and south are both 0.
- R6: When the centre is 1 and all three tests pass, `pix_out` is 0 and `erode_flag` is 1.
- R7: In every other case, `pix_out` equals the centre pixel and `erode_flag` is 0.
- R8: A background centre stays 0 and never raises `erode_flag`.
- R9: With REG_OUT=1 (the default), both outputs reflect the window of the previous clock. Both outputs read 0 while reset is active. Reset is asserted asynchronously and released on the clock, two edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| win | input | 9 | 3x3 window, numbered as in R1 |
| pass_sel | input | 1 | Selects the directional rule of pass 0 or pass 1 |
| pix_out | output | 1 | Next value of the centre pixel |
| erode_flag | output | 1 | High when a foreground centre is removed |

## Verification
The assertions hold on every cycle for these properties: an erosion always yields a 0 pixel, a background centre is never touched, and windows whose count is out of range or whose directional rule fails for the current pass keep their centre. Only the bench can show that erosion actually happens in the right cases. It does this with directed windows that test each rule at its boundary: counts of 2 and 6, two separate regions, and patterns that erode in one pass but not the other. It also sweeps every window against a model written from the requirements. The bench alone checks the reset values and the delay through the output stage.

// File: rtl/thin_pkg.sv
package thin_pkg;
  localparam int WIN_W  = 9;
  localparam int NBR_N  = 8;
  localparam int CNT_W  = $clog2(NBR_N) + 1;
  localparam int CTR    = 4;

  typedef struct packed {
    logic n;
    logic e;
    logic s;
    logic w;
  } edge_nbr_t;

  // clockwise ring starting top-left
  function automatic logic [NBR_N-1:0] ring_of(input logic [WIN_W-1:0] wv);
    logic [NBR_N-1:0] r;
    r[0] = wv[6];
    r[1] = wv[7];
    r[2] = wv[8];
    r[3] = wv[5];
    r[4] = wv[2];
    r[5] = wv[1];
    r[6] = wv[0];
    r[7] = wv[3];
    return r;
  endfunction
endpackage

// File: rtl/thin_nbr_count.sv
module thin_nbr_count
  import thin_pkg::*;
#(
  parameter int N  = NBR_N,
  parameter int CW = CNT_W
) (
  input  logic [N-1:0] ring,
  output logic         cnt_ok
);
  // binary adder tree: leaves at N..2N-1, root at 1
  logic [CW-1:0] node [1:2*N-1];
  logic [CW-1:0] sum;

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign node[N+i] = CW'(ring[i]);
  end
  for (genvar j = 1; j < N; j++) begin : g_add
    assign node[j] = node[2*j] + node[2*j+1];
  end
  assign sum = node[1];

  // accept counts 2..6 (R2)
  always_comb begin
    cnt_ok = (sum[1] ^ sum[2])
           | (sum[0] & ~sum[1] & sum[3])
           | (~sum[0] & sum[1] & ~sum[3]);
  end
endmodule

// File: rtl/thin_xing_test.sv
module thin_xing_test
  import thin_pkg::*;
#(
  parameter int N = NBR_N
) (
  input  logic [N-1:0] ring,
  output logic         xing_ok
);
  logic [N-1:0] rise;

  for (genvar i = 0; i < N; i++) begin : g_step
    assign rise[i] = ~ring[i] & ring[(i+1) % N];
  end

  // exactly one 0->1 step around the ring (R3)
  assign xing_ok = $onehot(rise);
endmodule

// File: rtl/thin_pass_test.sv
module thin_pass_test
  import thin_pkg::*;
(
  input  edge_nbr_t ed,
  input  logic      pass_sel,
  output logic      pass_ok
);
  logic ok_a;
  logic ok_b;

  always_comb begin
    ok_a = ~ed.e | ~ed.s | (~ed.n & ~ed.w);  // R4
    ok_b = ~ed.n | ~ed.w | (~ed.e & ~ed.s);  // R5
    pass_ok = pass_sel ? ok_b : ok_a;
  end
endmodule

// File: rtl/thin_rst_sync.sv
module thin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_q_n = sh_q[1];
endmodule

// File: rtl/thin_erode_slice.sv
module thin_erode_slice
  import thin_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win,
  input  logic             pass_sel,
  output logic             pix_out,
  output logic             erode_flag
);
  logic [NBR_N-1:0] ring;
  edge_nbr_t        ed;
  logic             cnt_ok;
  logic             xing_ok;
  logic             pass_ok;
  logic             erode_c;
  logic             pix_c;
  logic             rst_q_n;

  assign ring = ring_of(win);  // R1
  assign ed   = '{n: win[7], e: win[5], s: win[1], w: win[3]};

  thin_nbr_count #(.N(NBR_N), .CW(CNT_W)) u_cnt (
    .ring   (ring),
    .cnt_ok (cnt_ok)
  );

  thin_xing_test #(.N(NBR_N)) u_xing (
    .ring    (ring),
    .xing_ok (xing_ok)
  );

  thin_pass_test u_pass (
    .ed       (ed),
    .pass_sel (pass_sel),
    .pass_ok  (pass_ok)
  );

  // R6/R7/R8: only a foreground centre may be removed
  always_comb begin
    erode_c = win[CTR] & cnt_ok & xing_ok & pass_ok;
    pix_c   = win[CTR] & ~erode_c;
  end

  if (REG_OUT) begin : g_reg
    logic pix_d, flg_d;
    logic pix_q, flg_q;
    logic ld_en;

    thin_rst_sync u_rsync (
      .clk     (clk),
      .rst_n   (rst_n),
      .rst_q_n (rst_q_n)
    );

    assign ld_en = 1'b1;

    always_comb begin
      pix_d = pix_q;
      flg_d = flg_q;
      if (ld_en) begin
        pix_d = pix_c;
        flg_d = erode_c;
      end
    end

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        pix_q <= 1'b0;
        flg_q <= 1'b0;
      end else begin
        pix_q <= pix_d;
        flg_q <= flg_d;
      end
    end

    assign pix_out    = pix_q;
    assign erode_flag = flg_q;
  end else begin : g_comb
    assign rst_q_n    = rst_n;
    assign pix_out    = pix_c;
    assign erode_flag = erode_c;
  end
endmodule

// File: rtl/thin_erode_chk.sv
module thin_erode_chk
  import thin_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic [WIN_W-1:0] win,
  input logic             pass_sel,
  input logic             pix_out,
  input logic             erode_flag
);
  int unsigned ncnt;
  logic        blk0;
  logic        blk1;

  assign ncnt = $countones({win[8:5], win[3:0]});
  assign blk0 = !pass_sel && win[5] && win[1] && (win[7] || win[3]);
  assign blk1 =  pass_sel && win[7] && win[3] && (win[5] || win[1]);

  AST_ERODE_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    erode_flag |-> !pix_out); // R6

  if (REG_OUT) begin : g_seq
    AST_BG_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
      !win[CTR] |=> (!pix_out && !erode_flag)); // R8
    AST_CNT_LOW: assert property (@(posedge clk) disable iff (!rst_q_n)
      (ncnt < 2) |=> (pix_out == $past(win[CTR]) && !erode_flag)); // R2
    AST_CNT_HIGH: assert property (@(posedge clk) disable iff (!rst_q_n)
      (ncnt > 6) |=> (pix_out == $past(win[CTR]) && !erode_flag)); // R2
    AST_PASS0_BLOCK: assert property (@(posedge clk) disable iff (!rst_q_n)
      blk0 |=> (pix_out == $past(win[CTR]))); // R4
    AST_PASS1_BLOCK: assert property (@(posedge clk) disable iff (!rst_q_n)
      blk1 |=> (pix_out == $past(win[CTR]))); // R5
  end else begin : g_cmb
    AST_BG_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
      !win[CTR] |-> (!pix_out && !erode_flag)); // R8
    AST_CNT_LOW: assert property (@(posedge clk) disable iff (!rst_q_n)
      (ncnt < 2) |-> (pix_out == win[CTR])); // R2
    AST_CNT_HIGH: assert property (@(posedge clk) disable iff (!rst_q_n)
      (ncnt > 6) |-> (pix_out == win[CTR])); // R2
    AST_PASS0_BLOCK: assert property (@(posedge clk) disable iff (!rst_q_n)
      blk0 |-> (pix_out == win[CTR])); // R4
    AST_PASS1_BLOCK: assert property (@(posedge clk) disable iff (!rst_q_n)
      blk1 |-> (pix_out == win[CTR])); // R5
  end
endmodule

bind thin_erode_slice thin_erode_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .win        (win),
  .pass_sel   (pass_sel),
  .pix_out    (pix_out),
  .erode_flag (erode_flag)
);

// File: tb/thin_erode_slice_bench.sv
`timescale 1ns/1ps
module thin_erode_slice_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] win;
  logic       pass_sel;
  logic       pix_out;
  logic       erode_flag;
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;

  always #4 clk = ~clk;

  thin_erode_slice u_thin_erode_slice (
    .clk        (clk),
    .rst_n      (rst_n),
    .win        (win),
    .pass_sel   (pass_sel),
    .pix_out    (pix_out),
    .erode_flag (erode_flag)
  );

  // model built from R1..R8
  function automatic logic [1:0] model(input logic [8:0] w, input logic ps);
    logic [7:0] q;
    int cnt, rises;
    logic c_ok, x_ok, p_ok, er;
    q = {w[3], w[0], w[1], w[2], w[5], w[8], w[7], w[6]};  // q7..q0 (R1)
    cnt = 0; rises = 0;
    for (int i = 0; i < 8; i++) begin
      cnt += int'(q[i]);
      if (!q[i] && q[(i+1)%8]) rises++;
    end
    c_ok = (cnt >= 2) && (cnt <= 6);                          // R2
    x_ok = (rises == 1);                                      // R3
    if (!ps) p_ok = !w[5] || !w[1] || (!w[7] && !w[3]);       // R4
    else     p_ok = !w[7] || !w[3] || (!w[5] && !w[1]);       // R5
    er = w[4] && c_ok && x_ok && p_ok;                        // R6
    return {w[4] && !er, er};
  endfunction

  task automatic chk(input string req, input logic ap, input logic ep,
                     input logic af, input logic ef);
    n_chk++;
    if (ap !== ep || af !== ef) begin
      n_fail++;
      $display("FAIL %s: got pix=%b flag=%b expected pix=%b flag=%b",
               req, ap, af, ep, ef);
    end
  endtask

  // drive on a falling edge, sample one falling edge later (one register)
  task automatic apply(input string req, input logic [8:0] w, input logic ps);
    logic [1:0] e;
    @(negedge clk);
    win = w; pass_sel = ps;
    @(negedge clk);
    e = model(w, ps);
    chk(req, pix_out, e[1], erode_flag, e[0]);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; win = 9'h1FF; pass_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset", pix_out, 1'b0, erode_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset hold", pix_out, 1'b0, erode_flag, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_latency;
    @(negedge clk); win = 9'b000011011; pass_sel = 1'b0;
    #1;
    chk("R9 before edge", pix_out, 1'b1, erode_flag, 1'b0);
    @(negedge clk);
    chk("R9 after edge", pix_out, 1'b0, erode_flag, 1'b1);
  endtask

  task automatic t_basic;
    apply("R6 corner pass0", 9'b000011011, 1'b0);
    chk("R6 corner pass0 flag", erode_flag, 1'b1, pix_out, 1'b0);
    apply("R6 corner pass1", 9'b000011011, 1'b1);
    chk("R1 orientation", erode_flag, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_count;
    apply("R2 one neighbour", 9'b000010001, 1'b0);
    chk("R2 endpoint kept", pix_out, 1'b1, erode_flag, 1'b0);
    apply("R2 count two", 9'b000010011, 1'b0);
    chk("R2 count two erodes", pix_out, 1'b0, erode_flag, 1'b1);
    apply("R2 count seven", 9'b111011111, 1'b0);
    chk("R2 count seven kept", pix_out, 1'b1, erode_flag, 1'b0);
    apply("R2 count six", 9'b100111111, 1'b1);
    chk("R2 count six erodes", pix_out, 1'b0, erode_flag, 1'b1);
  endtask

  task automatic t_xing;
    apply("R3 two regions", 9'b010010010, 1'b0);
    chk("R3 bridge kept", pix_out, 1'b1, erode_flag, 1'b0);
    apply("R3 two regions p1", 9'b010010010, 1'b1);
    chk("R3 bridge kept p1", pix_out, 1'b1, erode_flag, 1'b0);
  endtask

  task automatic t_pass;
    apply("R4 pass0 erodes", 9'b011011011, 1'b0);
    chk("R4 pass0 result", pix_out, 1'b0, erode_flag, 1'b1);
    apply("R5 pass1 blocks", 9'b011011011, 1'b1);
    chk("R5 pass1 result", pix_out, 1'b1, erode_flag, 1'b0);
    apply("R4 pass0 blocks", 9'b100111111, 1'b0);
    chk("R4 pass0 keep", pix_out, 1'b1, erode_flag, 1'b0);
    apply("R5 pass1 erodes", 9'b100111111, 1'b1);
    chk("R5 pass1 result2", pix_out, 1'b0, erode_flag, 1'b1);
  endtask

  task automatic t_background;
    apply("R8 background", 9'b000001011, 1'b0);
    chk("R8 background stays", pix_out, 1'b0, erode_flag, 1'b0);
    apply("R7 solid block", 9'b111111111, 1'b1);
    chk("R7 interior kept", pix_out, 1'b1, erode_flag, 1'b0);
  endtask

  task automatic t_sweep;
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 512; v++) begin
        apply("R7 sweep", 9'(v), 1'(p));
      end
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_basic();
    t_count();
    t_xing();
    t_pass();
    t_background();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule